// File: doc/BRIEF.md
# Internal I/O Space Address Router

This block sits at the front of the address path for a special internal address space that carries no ordinary memory. Each request names an address, a byte count, a write flag and write data. The block drops the three lowest address bits and splits the remainder into a space selector and a field. It then returns a routed physical address, together with an uncacheable flag, a register-access flag and a fault code, in the same cycle. Three selector values are recognised: processor identification, model-specific registers, and I/O ports. All other values fault.

For I/O ports, the block emulates the legacy configuration-space mechanism. A 32-bit configuration address register is reached through port 0xCF8 with four-byte accesses, and a four-byte write there loads it. The four data ports 0xCFC to 0xCFF are redirected into a configuration-space window while the register's enable bit is set. All other ports go to a plain I/O window. Model-specific register numbers are looked up in two parameterised windows. A known number becomes a register access at its index times the register width. An unknown number raises a general protection fault.

Top module: `ioaddr_router`

## Requirements
- R1: With default parameters, the selector is req_addr[47:35] and the field is req_addr[34:3]. Selector 0 is identification, 1 is model registers, 2 is I/O. Any other selector gives rsp_fault=3, and every faulting response has rsp_paddr=0 and both flags low.
- R2: A request to the identification space gives rsp_fault=2 (unsupported).
- R3: An I/O request whose field has any bit above bit 15 set gives rsp_fault=3. Otherwise the port number is field[15:0].
- R4: A 4-byte I/O access to port 0xCF8 gives rsp_regacc=1, rsp_uncache=0, and rsp_paddr = CFGREG_IDX*REG_BYTES (0x800 by default). The two flags are never high together.
- R5: The configuration address register resets to zero. It loads req_wdata on the clock edge that ends a valid 4-byte write to port 0xCF8, and no other request changes it.
- R6: An access of any size to ports 0xCFC to 0xCFF, while bit 31 of the configuration register is set, gives rsp_uncache=1 and rsp_paddr = 0xC000_0000_0000_0000 | {cfg[30:2],2'b00} | port[1:0].
- R7: Any other I/O access, including data ports while bit 31 is clear and 0xCF8 at sizes other than 4, gives rsp_uncache=1 and rsp_paddr = 0x8000_0000_0000_0000 | port.
- R8: The model-register numbers 0x10 to 0x17 map to indexes 0 to 7, and 0xC000_0080 to 0xC000_0083 map to indexes 8 to 11. A hit gives rsp_regacc=1 and rsp_paddr = index*8.
- R9: A model-register number outside both windows gives rsp_fault=1 (general protection).
- R10: With req_valid low, all outputs are zero and the configuration register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W (48) | Internal-space address |
| req_size | input | 4 | Access size in bytes |
| req_wr | input | 1 | Request is a write |
| req_wdata | input | 32 | Write data for the configuration register |
| rsp_paddr | output | PA_W (64) | Routed physical address |
| rsp_uncache | output | 1 | Access must bypass caches |
| rsp_regacc | output | 1 | Access targets an internal register |
| rsp_fault | output | 2 | 0 none, 1 protection, 2 unsupported, 3 bad space |

## Verification
Several properties are checked on every cycle. A faulting response carries no address and no flags, the two flags exclude each other, and an idle cycle yields all-zero outputs. The configuration register holds its value unless a four-byte write is seen, and any configuration-window address implies that the enable bit is latched. Only the bench's sweeps can show that each port, size, register number and selector value lands at the exact address expected. The same holds for a write having the right effect, and for writes with the wrong size, port or direction being ignored, which is visible only through later data-port routing.

// File: rtl/ioaddr_pkg.sv
`timescale 1ns/1ps
package ioaddr_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_GP    = 2'd1,
        FLT_UNSUP = 2'd2,
        FLT_SPACE = 2'd3
    } fault_e;

    typedef struct packed {
        logic [31:0] cfg;
    } state_t;

endpackage

// File: rtl/ioaddr_msr_map.sv
`timescale 1ns/1ps
module ioaddr_msr_map #(
    parameter int              FIELD_W = 32,
    parameter logic [31:0]     A_BASE  = 32'h0000_0010,
    parameter int              A_CNT   = 8,
    parameter logic [31:0]     B_BASE  = 32'hC000_0080,
    parameter int              B_CNT   = 4,
    parameter int              IDX_W   = 4
) (
    input  logic [FIELD_W-1:0] num,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    localparam int NWIN = 2;
    localparam logic [FIELD_W-1:0] WIN_BASE [NWIN] = '{FIELD_W'(A_BASE), FIELD_W'(B_BASE)};
    localparam int                 WIN_CNT  [NWIN] = '{A_CNT, B_CNT};
    localparam int                 WIN_OFS  [NWIN] = '{0, A_CNT};

    logic [NWIN-1:0]  hit_w;
    logic [IDX_W-1:0] idx_w [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [FIELD_W-1:0] off;
        assign off      = num - WIN_BASE[w];
        assign hit_w[w] = (num >= WIN_BASE[w]) && (off < FIELD_W'(WIN_CNT[w]));
        assign idx_w[w] = IDX_W'(off) + IDX_W'(WIN_OFS[w]);
    end

    always_comb begin
        hit = |hit_w;
        idx = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_w[w]) idx = idx_w[w];
        end
    end
endmodule

// File: rtl/ioaddr_io_route.sv
`timescale 1ns/1ps
module ioaddr_io_route #(
    parameter int              PA_W        = 64,
    parameter logic [15:0]     CFG_PORT    = 16'hCF8,
    parameter logic [15:0]     DATA_PORT   = 16'hCFC,
    parameter logic [PA_W-1:0] PA_IO_BASE  = 64'h8000_0000_0000_0000,
    parameter logic [PA_W-1:0] PA_CFG_BASE = 64'hC000_0000_0000_0000,
    parameter logic [PA_W-1:0] PA_CFGREG   = 64'h800
) (
    input  logic [15:0]     port,
    input  logic [3:0]      size,
    input  logic [31:0]     cfg,
    output logic [PA_W-1:0] paddr,
    output logic            uncache,
    output logic            regacc,
    output logic            cfg_hit
);
    logic data_hit;
    logic unused_cfg;
    assign unused_cfg = ^cfg[1:0];

    assign cfg_hit  = (port == CFG_PORT) && (size == 4'd4);
    assign data_hit = (port[15:2] == DATA_PORT[15:2]);

    always_comb begin
        paddr   = PA_IO_BASE | PA_W'(port);
        uncache = 1'b1;
        regacc  = 1'b0;
        if (cfg_hit) begin
            paddr   = PA_CFGREG;
            uncache = 1'b0;
            regacc  = 1'b1;
        end else if (data_hit && cfg[31]) begin
            paddr = PA_CFG_BASE | PA_W'({cfg[30:2], 2'b00}) | PA_W'(port[1:0]);
        end
    end
endmodule

// File: rtl/ioaddr_router.sv
`timescale 1ns/1ps
module ioaddr_router
    import ioaddr_pkg::*;
#(
    parameter int              ADDR_W      = 48,
    parameter int              FIELD_W     = 32,
    parameter int              PA_W        = 64,
    parameter int              REG_BYTES   = 8,
    parameter int              CFGREG_IDX  = 256,
    parameter int              SEL_ID      = 0,
    parameter int              SEL_MSR     = 1,
    parameter int              SEL_IO      = 2,
    parameter logic [PA_W-1:0] PA_IO_BASE  = 64'h8000_0000_0000_0000,
    parameter logic [PA_W-1:0] PA_CFG_BASE = 64'hC000_0000_0000_0000,
    parameter int              MSR_A_CNT   = 8,
    parameter int              MSR_B_CNT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic              req_wr,
    input  logic [31:0]       req_wdata,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_uncache,
    output logic              rsp_regacc,
    output logic [1:0]        rsp_fault
);
    localparam int SEL_W = ADDR_W - 3 - FIELD_W;
    localparam int IDX_W = $clog2(MSR_A_CNT + MSR_B_CNT);
    localparam logic [PA_W-1:0] PA_CFGREG = PA_W'(CFGREG_IDX) * PA_W'(REG_BYTES);

    typedef struct packed {
        logic [PA_W-1:0] paddr;
        logic            uncache;
        logic            regacc;
        fault_e          fault;
    } rsp_t;

    state_t st_d, st_q;
    rsp_t   rsp;

    logic [SEL_W-1:0]   sel;
    logic [FIELD_W-1:0] field;
    logic               unused_low;
    assign sel        = req_addr[ADDR_W-1 -: SEL_W];
    assign field      = req_addr[3 +: FIELD_W];
    assign unused_low = ^req_addr[2:0];

    logic             msr_hit;
    logic [IDX_W-1:0] msr_idx;
    ioaddr_msr_map #(
        .FIELD_W (FIELD_W),
        .A_CNT   (MSR_A_CNT),
        .B_CNT   (MSR_B_CNT),
        .IDX_W   (IDX_W)
    ) u_msr (
        .num (field),
        .hit (msr_hit),
        .idx (msr_idx)
    );

    logic [PA_W-1:0] io_paddr;
    logic            io_unc, io_reg, io_cfg_hit;
    ioaddr_io_route #(
        .PA_W        (PA_W),
        .PA_IO_BASE  (PA_IO_BASE),
        .PA_CFG_BASE (PA_CFG_BASE),
        .PA_CFGREG   (PA_CFGREG)
    ) u_io (
        .port    (field[15:0]),
        .size    (req_size),
        .cfg     (st_q.cfg),
        .paddr   (io_paddr),
        .uncache (io_unc),
        .regacc  (io_reg),
        .cfg_hit (io_cfg_hit)
    );

    always_comb begin
        st_d = st_q;
        rsp  = '{paddr: '0, uncache: 1'b0, regacc: 1'b0, fault: FLT_NONE};
        if (req_valid) begin
            if (sel == SEL_W'(SEL_ID)) begin
                rsp.fault = FLT_UNSUP;
            end else if (sel == SEL_W'(SEL_MSR)) begin
                if (msr_hit) begin
                    rsp.paddr  = PA_W'(msr_idx) * PA_W'(REG_BYTES);
                    rsp.regacc = 1'b1;
                end else begin
                    rsp.fault = FLT_GP;
                end
            end else if (sel == SEL_W'(SEL_IO)) begin
                if (field[FIELD_W-1:16] != '0) begin
                    rsp.fault = FLT_SPACE;
                end else begin
                    rsp.paddr   = io_paddr;
                    rsp.uncache = io_unc;
                    rsp.regacc  = io_reg;
                    if (io_cfg_hit && req_wr) st_d.cfg = req_wdata;
                end
            end else begin
                rsp.fault = FLT_SPACE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_paddr   = rsp.paddr;
    assign rsp_uncache = rsp.uncache;
    assign rsp_regacc  = rsp.regacc;
    assign rsp_fault   = rsp.fault;

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != 2'd0) |-> (rsp_paddr == '0 && !rsp_uncache && !rsp_regacc)); // R1
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_uncache && rsp_regacc)); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (rsp_paddr == '0 && !rsp_uncache && !rsp_regacc && rsp_fault == 2'd0)); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_wr && req_size == 4'd4) |=> $stable(st_q.cfg)); // R5
    AST_CFG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_uncache && ((rsp_paddr & PA_CFG_BASE) == PA_CFG_BASE)) |-> st_q.cfg[31]); // R6
endmodule

// File: tb/ioaddr_router_test.sv
`timescale 1ns/1ps
module ioaddr_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_addr = '0;
    logic [3:0]  req_size = '0;
    logic        req_wr = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [63:0] rsp_paddr;
    logic        rsp_uncache, rsp_regacc;
    logic [1:0]  rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] cfg_m = '0;

    always #2.5 clk = ~clk;

    ioaddr_router uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_wr(req_wr), .req_wdata(req_wdata),
        .rsp_paddr(rsp_paddr), .rsp_uncache(rsp_uncache),
        .rsp_regacc(rsp_regacc), .rsp_fault(rsp_fault)
    );

    function automatic logic [47:0] mk(input logic [12:0] s, input logic [31:0] f);
        return {s, f, 3'b000};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected response from the requirements, by arithmetic.
    task automatic expect_rsp(input logic v, input logic [47:0] a, input logic [3:0] sz,
                              output logic [63:0] pa, output logic u, output logic r,
                              output logic [1:0] f, output string tag);
        logic [12:0] s;
        logic [31:0] fl;
        logic [15:0] p;
        s = a[47:35]; fl = a[34:3]; p = fl[15:0];
        pa = '0; u = 1'b0; r = 1'b0; f = 2'd0; tag = "R10";
        if (!v) return;
        if (s == 13'd0) begin f = 2'd2; tag = "R2"; end
        else if (s == 13'd1) begin
            if (fl >= 32'h10 && fl < 32'h18) begin r = 1'b1; pa = 64'(fl - 32'h10) * 8; tag = "R8"; end
            else if (fl >= 32'hC000_0080 && fl < 32'hC000_0084) begin
                r = 1'b1; pa = (64'(fl - 32'hC000_0080) + 8) * 8; tag = "R8";
            end else begin f = 2'd1; tag = "R9"; end
        end else if (s == 13'd2) begin
            if (fl[31:16] != 0) begin f = 2'd3; tag = "R3"; end
            else if (p == 16'hCF8 && sz == 4) begin r = 1'b1; pa = 64'h800; tag = "R4"; end
            else if (p >= 16'hCFC && p <= 16'hCFF && cfg_m[31]) begin
                u = 1'b1; tag = "R6";
                pa = 64'hC000_0000_0000_0000 + 64'(cfg_m & 32'h7FFF_FFFC) + 64'(p - 16'hCFC);
            end else begin u = 1'b1; pa = 64'h8000_0000_0000_0000 + 64'(p); tag = "R7"; end
        end else begin f = 2'd3; tag = "R1"; end
    endtask

    task automatic drive(input logic v, input logic [47:0] a, input logic [3:0] sz,
                         input logic w, input logic [31:0] d);
        logic [63:0] pa; logic u, r; logic [1:0] f; string tag;
        @(negedge clk);
        req_valid = v; req_addr = a; req_size = sz; req_wr = w; req_wdata = d;
        #1;
        expect_rsp(v, a, sz, pa, u, r, f, tag);
        chk({tag, " paddr"}, rsp_paddr, pa);
        chk({tag, " uncache"}, 64'(rsp_uncache), 64'(u));
        chk({tag, " regacc"}, 64'(rsp_regacc), 64'(r));
        chk({tag, " fault"}, 64'(rsp_fault), 64'(f));
        // R5: register model loads only on a valid 4-byte write to 0xCF8
        if (v && w && sz == 4 && a[47:35] == 13'd2 && a[34:3] == 32'h0000_0CF8) cfg_m = d;
    endtask

    task automatic set_cfg(input logic [31:0] d);
        drive(1'b1, mk(13'd2, 32'hCF8), 4'd4, 1'b1, d);
    endtask

    task automatic probe_data;
        for (int q = 0; q < 4; q++) drive(1'b1, mk(13'd2, 32'hCFC + q), 4'd4, 1'b0, '0);
    endtask

    initial begin
        logic [31:0] cfgs [4];
        cfgs[0] = 32'h0000_0000; cfgs[1] = 32'h8000_ABCC;
        cfgs[2] = 32'h7FFF_FFFF; cfgs[3] = 32'hFFFF_FFFF;
        #12 rst_n = 1'b1;
        // reset state: idle outputs zero, register zero so data ports go plain (R10, R5)
        drive(1'b0, '0, 4'd0, 1'b0, '0);
        probe_data();
        // R1 R2: selector sweep
        for (int s = 0; s < 16; s++) begin
            drive(1'b1, mk(13'(s), 32'h10), 4'd4, 1'b0, '0);
            drive(1'b1, mk(13'(s), 32'hCF8) | 48'h7, 4'd4, 1'b0, '0);
        end
        drive(1'b1, mk(13'h1FFF, 32'h0), 4'd1, 1'b0, '0);
        // R8 R9: model-register number sweep around both windows
        for (int n = 0; n < 32; n++) drive(1'b1, mk(13'd1, 32'(n)), 4'd8, 1'b0, '0);
        for (int n = 0; n < 16; n++) drive(1'b1, mk(13'd1, 32'hC000_007C + n), 4'd8, 1'b0, '0);
        drive(1'b1, mk(13'd1, 32'hFFFF_FFFF), 4'd8, 1'b0, '0);
        // R3: ports beyond 16 bits
        drive(1'b1, mk(13'd2, 32'h0001_0CF8), 4'd4, 1'b1, 32'h8000_0004);
        drive(1'b1, mk(13'd2, 32'h8000_0CFC), 4'd4, 1'b0, '0);
        probe_data();
        // R4 R6 R7: port x size x register-value sweep
        for (int c = 0; c < 4; c++) begin
            set_cfg(cfgs[c]);
            for (int p = 16'hCF0; p < 16'hD08; p++)
                for (int z = 0; z < 3; z++)
                    drive(1'b1, mk(13'd2, 32'(p)), 4'(1 << z), 1'b0, '0);
        end
        // R5: ignored writes, observed through data-port routing
        set_cfg(32'h8000_1230);
        drive(1'b1, mk(13'd2, 32'hCF8), 4'd2, 1'b1, 32'h8000_4440);
        probe_data();
        drive(1'b1, mk(13'd2, 32'hCFC), 4'd4, 1'b1, 32'h8000_5550);
        probe_data();
        drive(1'b1, mk(13'd3, 32'hCF8), 4'd4, 1'b1, 32'h0);
        drive(1'b1, mk(13'd1, 32'hCF8), 4'd4, 1'b1, 32'h0);
        probe_data();
        drive(1'b0, mk(13'd2, 32'hCF8), 4'd4, 1'b1, 32'h0); // R10: idle write ignored
        probe_data();
        set_cfg(32'h0000_1230);
        probe_data();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule